// File: doc/BRIEF.md
# Transmit FIFO with Interval Gap Scheduler

This block holds outgoing message words for one transmit channel of a CAN-style controller. Software writes words into a first-in, first-out store. Only the oldest stored word is offered to an external protocol engine, through a request and data pair. The engine reports back in three ways: it took the word (start), it sent the word (done), or the attempt failed through a bus error or lost arbitration.

A programmable gap timer controls the spacing of successful sends. Each successful send starts the timer at the engine's end-of-frame point. No new request is raised until the timer expires. The timer counts ticks from a prescaled system clock or from an external bit-time tick.

Clearing the enable discards all stored words. The empty indication is held back while a word is still with the engine, and is released once that attempt resolves.

Top module: `tx_gap_fifo`

## Requirements
- R1: Usable depth is `depth_sel_i`+1 entries (1 to 8), capped at the `DEPTH` parameter. Words leave in the order they were written, and only the oldest is ever driven on `tx_data_o`.
- R2: `full_o` is high when `count_o` equals the usable depth. A write while full is dropped and sets `ovf_o`. `ovf_o` stays high while enabled and clears only when disabled.
- R3: `tx_req_o` is high only when all of these hold: enabled, `chan_rst_i` low, at least one word stored, no gap running, and no word with the engine. `tx_start_i` while `tx_req_o` is high hands the oldest word to the engine, and `tx_req_o` drops the next cycle.
- R4: `tx_done_i` for the word with the engine removes it from the store. If `gap_len_i`=0, the next request appears the very next cycle. Otherwise `gap_busy_o` rises the next cycle and requests are held off.
- R5: `tx_err_i` or `tx_arb_lost_i` leaves the word in place and starts no gap. The same word is requested again the next cycle.
- R6: With `gap_src_i`=2'b00, one gap tick takes 2·M system clocks, where M is `presc_i` and 0 is treated as 1. `gap_busy_o` stays high for 2·M·N cycles after the done cycle, where N is `gap_len_i`.
- R7: With `gap_src_i`=2'b10, one gap tick takes 20·M system clocks, so the gap lasts 20·M·N cycles.
- R8: With `gap_src_i[0]`=1, the gap counts `bit_tick_i` pulses and ends on the Nth pulse seen while the gap runs.
- R9: When `en_i` is low, the store is emptied at the next edge, writes are ignored, `ovf_o` clears, and the gap timer stops and clears.
- R10: `empty_o` is high when no word is stored and none is with the engine. If the block is disabled while a word is with the engine, `empty_o` stays low until done, error or lost arbitration is reported.
- R11: `chan_rst_i` stops and clears the gap timer at the next edge and holds `tx_req_o` low while it is asserted. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low flushes and blocks writes |
| chan_rst_i | input | 1 | Channel held in reset; clears the gap timer and blocks requests |
| depth_sel_i | input | 3 | Usable depth minus one |
| gap_len_i | input | 8 | Gap length N in ticks; 0 means no gap |
| gap_src_i | input | 2 | Tick source: 00 = system/2M, 10 = system/20M, x1 = bit tick |
| presc_i | input | 16 | Prescale value M |
| bit_tick_i | input | 1 | One-cycle bit-time tick |
| push_i | input | 1 | Write strobe |
| push_data_i | input | DATA_W (32) | Word to write |
| tx_start_i | input | 1 | Engine takes the requested word |
| tx_done_i | input | 1 | Word sent successfully (end of frame) |
| tx_err_i | input | 1 | Attempt ended in a bus error |
| tx_arb_lost_i | input | 1 | Attempt lost arbitration |
| tx_req_o | output | 1 | Transmit request for the oldest word |
| tx_data_o | output | DATA_W (32) | Oldest stored word |
| count_o | output | CNT_W (4) | Number of stored words |
| full_o | output | 1 | Store at usable depth |
| empty_o | output | 1 | Nothing stored and nothing with the engine |
| ovf_o | output | 1 | Sticky dropped-write flag |
| gap_busy_o | output | 1 | Gap timer running |

## Verification
The assertions assume the engine follows a simple protocol. It raises `tx_start_i` only while `tx_req_o` is high. It reports done, error or lost arbitration at most once per start, and never two of them together. The stimulus drives every engine pulse from a single task that first waits for a request and then issues start and one outcome, each one cycle long. Configuration inputs change only while no gap is running, so every gap-length property sees a steady source and prescale.

// File: rtl/tx_gap_pkg.sv
`timescale 1ns/1ps
package tx_gap_pkg;
  // tick source codes
  typedef enum logic [1:0] {
    SRC_SYS     = 2'b00,
    SRC_TICK    = 2'b01,
    SRC_SYS10   = 2'b10,
    SRC_TICK_B  = 2'b11
  } gap_src_e;

  localparam int SYS_DIV   = 2;
  localparam int SYS10_DIV = 20;

  function automatic logic src_is_tick(input logic [1:0] s);
    return s[0];
  endfunction
endpackage

// File: rtl/tx_gap_store.sv
`timescale 1ns/1ps
module tx_gap_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int SEL_W  = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [SEL_W-1:0]  depth_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cap;
  logic              do_push, do_pop;

  always_comb begin
    cap = CW'(DEPTH);
    if (int'(depth_sel_i) + 1 < DEPTH) cap = CW'(int'(depth_sel_i) + 1);
  end

  assign full_o  = (count_o >= cap);
  assign do_push = push_i && !flush_i && !full_o;
  assign do_pop  = pop_i && !flush_i && (count_o != '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R1: occupancy never exceeds physical storage
  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  // R2: a write into a full store leaves occupancy unchanged
  assert_full_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/tx_gap_prescale.sv
`timescale 1ns/1ps
module tx_gap_prescale
  import tx_gap_pkg::*;
#(
  parameter int PRESC_W = 16,
  localparam int LIM_W  = PRESC_W + 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               run_i,
  input  logic [1:0]         src_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               bit_tick_i,
  output logic               tick_o
);
  logic [LIM_W-1:0] m_eff, lim, pre;
  logic             wrap;

  always_comb begin
    m_eff = (presc_i == '0) ? LIM_W'(1) : LIM_W'(presc_i);
    lim   = src_i[1] ? m_eff * LIM_W'(SYS10_DIV) : m_eff * LIM_W'(SYS_DIV);
  end

  assign wrap   = (pre == lim - 1'b1);
  assign tick_o = src_is_tick(src_i) ? (run_i && bit_tick_i) : (run_i && wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pre <= '0;
    else if (clr_i || !run_i)             pre <= '0;
    else if (!src_is_tick(src_i))         pre <= wrap ? '0 : pre + 1'b1;
  end

  // R6: prescaler never runs past its limit
  assert_pre_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !src_is_tick(src_i) && $stable(src_i) && $stable(presc_i))
      |=> (pre < lim));
endmodule

// File: rtl/tx_gap_timer.sv
`timescale 1ns/1ps
module tx_gap_timer #(
  parameter int GAP_W   = 8,
  parameter int PRESC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [GAP_W-1:0]   len_i,
  input  logic [1:0]         src_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               bit_tick_i,
  output logic               busy_o
);
  logic [GAP_W-1:0] cnt;
  logic             tick;

  assign busy_o = (cnt != '0);

  tx_gap_prescale #(.PRESC_W(PRESC_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i || load_i),
    .run_i      (busy_o),
    .src_i      (src_i),
    .presc_i    (presc_i),
    .bit_tick_i (bit_tick_i),
    .tick_o     (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (clr_i)            cnt <= '0;
    else if (load_i)           cnt <= len_i;
    else if (tick && busy_o)   cnt <= cnt - 1'b1;
  end

  // R4: a load with nonzero length starts the gap
  assert_gap_starts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && len_i != '0) |=> busy_o);

  // R6: without a tick the remaining gap holds
  assert_gap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i && !load_i && !tick) |=> $stable(cnt));

  // R11: clear always stops the gap
  assert_gap_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/tx_gap_fifo.sv
`timescale 1ns/1ps
module tx_gap_fifo #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int SEL_W   = 3,
  parameter int GAP_W   = 8,
  parameter int PRESC_W = 16,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               chan_rst_i,
  input  logic [SEL_W-1:0]   depth_sel_i,
  input  logic [GAP_W-1:0]   gap_len_i,
  input  logic [1:0]         gap_src_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               bit_tick_i,
  input  logic               push_i,
  input  logic [DATA_W-1:0]  push_data_i,
  input  logic               tx_start_i,
  input  logic               tx_done_i,
  input  logic               tx_err_i,
  input  logic               tx_arb_lost_i,
  output logic               tx_req_o,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               ovf_o,
  output logic               gap_busy_o
);
  logic in_flight, resolve, pop, gap_load, gap_clr, stored;

  assign stored   = (count_o != '0);
  assign resolve  = tx_done_i || tx_err_i || tx_arb_lost_i;
  assign pop      = en_i && in_flight && tx_done_i;
  assign gap_load = pop && (gap_len_i != '0);
  assign gap_clr  = !en_i || chan_rst_i;

  tx_gap_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .SEL_W  (SEL_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (!en_i),
    .push_i      (push_i),
    .pop_i       (pop),
    .depth_sel_i (depth_sel_i),
    .wdata_i     (push_data_i),
    .head_o      (tx_data_o),
    .count_o     (count_o),
    .full_o      (full_o)
  );

  tx_gap_timer #(
    .GAP_W   (GAP_W),
    .PRESC_W (PRESC_W)
  ) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (gap_clr),
    .load_i     (gap_load),
    .len_i      (gap_len_i),
    .src_i      (gap_src_i),
    .presc_i    (presc_i),
    .bit_tick_i (bit_tick_i),
    .busy_o     (gap_busy_o)
  );

  assign tx_req_o = en_i && !chan_rst_i && stored && !gap_busy_o && !in_flight;
  assign empty_o  = !stored && !in_flight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       in_flight <= 1'b0;
    else if (resolve)                  in_flight <= 1'b0;
    else if (tx_start_i && tx_req_o)   in_flight <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovf_o <= 1'b0;
    else if (!en_i)                    ovf_o <= 1'b0;
    else if (push_i && full_o)         ovf_o <= 1'b1;
  end

  // R2: overflow flag is sticky while enabled
  assert_ovf_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && en_i) |=> ovf_o);

  // R3: a granted request drops the next cycle
  assert_grant_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_i && tx_req_o && !resolve) |=> !tx_req_o);

  // R4: successful send with a gap blocks the next request
  assert_gap_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_flight && tx_done_i && en_i && gap_len_i != '0) |=> !tx_req_o);

  // R5: failed attempt keeps the head in place
  assert_retry_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_flight && (tx_err_i || tx_arb_lost_i) && !tx_done_i && en_i && !push_i)
      |=> ($stable(count_o) && !gap_busy_o));

  // R9: disable flushes storage at the next edge
  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_o == '0));

  // R10: empty stays deferred while the engine still owns a word
  assert_empty_deferred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && in_flight && !resolve) |=> !empty_o);
endmodule

// File: tb/tx_gap_fifo_tb.sv
`timescale 1ns/1ps
module tx_gap_fifo_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, chan_rst_i = 1'b0;
  logic [2:0]  depth_sel_i = 3'd7;
  logic [7:0]  gap_len_i = 8'd0;
  logic [1:0]  gap_src_i = 2'b00;
  logic [15:0] presc_i = 16'd1;
  logic        bit_tick_i = 1'b0, push_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic        tx_start_i = 1'b0, tx_done_i = 1'b0, tx_err_i = 1'b0, tx_arb_lost_i = 1'b0;
  logic        tx_req_o, full_o, empty_o, ovf_o, gap_busy_o;
  logic [31:0] tx_data_o;
  logic [3:0]  count_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done_flag = 0;

  always #2.5 clk_i = ~clk_i;

  tx_gap_fifo u_dut (
    .clk_i, .rst_ni, .en_i, .chan_rst_i, .depth_sel_i, .gap_len_i, .gap_src_i,
    .presc_i, .bit_tick_i, .push_i, .push_data_i, .tx_start_i, .tx_done_i,
    .tx_err_i, .tx_arb_lost_i, .tx_req_o, .tx_data_o, .count_o, .full_o,
    .empty_o, .ovf_o, .gap_busy_o
  );

  // gap vectors: source, prescale, length, expected cycles (or pulses for bit source)
  localparam int NV = 6;
  localparam int V_SRC [NV] = '{0, 2, 0, 1, 3, 0};
  localparam int V_M   [NV] = '{3, 1, 0, 9, 9, 5};
  localparam int V_N   [NV] = '{2, 3, 4, 5, 2, 0};
  localparam int V_EXP [NV] = '{12, 60, 8, 5, 2, 0};

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    push_i = 1'b1; push_data_i = d; step(); push_i = 1'b0;
  endtask

  task automatic wait_req();
    for (int g = 0; g < 2000 && !tx_req_o; g++) step();
  endtask

  task automatic start_tx();
    wait_req(); tx_start_i = 1'b1; step(); tx_start_i = 1'b0;
  endtask

  task automatic send_ok();
    start_tx(); tx_done_i = 1'b1; step(); tx_done_i = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    // reset state
    check("R3 reset req", tx_req_o, 0);
    check("R10 reset empty", empty_o, 1);
    check("R2 reset full/ovf", {full_o, ovf_o}, 0);
    check("R1 reset count", count_o, 0);
    rst_ni = 1'b1; en_i = 1'b1; step();

    // R1/R2: depth 3, order, overflow
    depth_sel_i = 3'd2; gap_len_i = 0;
    push(32'hA1); push(32'hA2); push(32'hA3);
    check("R2 full at depth", full_o, 1);
    check("R1 count 3", count_o, 3);
    check("R1 head first", tx_data_o, 32'hA1);
    push(32'hA4);
    check("R2 ovf set", ovf_o, 1);
    check("R2 drop count", count_o, 3);
    send_ok();
    check("R4 back-to-back req", tx_req_o, 1);
    check("R1 order 2", tx_data_o, 32'hA2);
    check("R4 no gap", gap_busy_o, 0);
    send_ok();
    check("R1 order 3", tx_data_o, 32'hA3);
    send_ok();
    check("R1 drained", {count_o, empty_o}, {4'd0, 1'b1});
    check("R2 ovf sticky", ovf_o, 1);
    depth_sel_i = 3'd7;

    // R5: error and lost arbitration keep the head
    push(32'hB1); push(32'hB2);
    start_tx();
    check("R3 req drops on grant", tx_req_o, 0);
    tx_err_i = 1'b1; step(); tx_err_i = 1'b0;
    check("R5 err re-request", {tx_req_o, gap_busy_o}, {1'b1, 1'b0});
    check("R5 err head kept", {tx_data_o, count_o}, {32'hB1, 4'd2});
    start_tx();
    tx_arb_lost_i = 1'b1; step(); tx_arb_lost_i = 1'b0;
    check("R5 arb re-request", tx_req_o, 1);
    check("R5 arb head kept", {tx_data_o, count_o}, {32'hB1, 4'd2});
    send_ok(); send_ok();

    // R6/R7/R8: gap length vectors
    for (int v = 0; v < NV; v++) begin
      int cyc_n, pulses, measured;
      gap_src_i = 2'(V_SRC[v]); presc_i = 16'(V_M[v]); gap_len_i = 8'(V_N[v]);
      push(32'hC0 + 32'(v));
      send_ok();
      cyc_n = 0; pulses = 0;
      while (gap_busy_o && cyc_n < 5000) begin
        bit_tick_i = ((cyc_n % 3) == 2);
        step();
        if (bit_tick_i) pulses++;
        bit_tick_i = 1'b0;
        cyc_n++;
      end
      measured = (V_SRC[v] % 2 == 1) ? pulses : cyc_n;
      check($sformatf("R6 R7 R8 gap vector %0d", v), 64'(measured), 64'(V_EXP[v]));
    end

    // R3: request held off while the gap runs (2*1*3 = 6 cycles)
    gap_src_i = 2'b00; presc_i = 16'd1; gap_len_i = 8'd3;
    push(32'hD1); push(32'hD2);
    send_ok();
    check("R3 held during gap", {tx_req_o, gap_busy_o, count_o}, {1'b0, 1'b1, 4'd1});
    repeat (5) step();
    check("R3 still held", tx_req_o, 0);
    step();
    check("R3 req after gap", {tx_req_o, tx_data_o}, {1'b1, 32'hD2});

    // R11: channel reset clears the gap and blocks requests
    push(32'hD3);
    send_ok();
    step();
    chan_rst_i = 1'b1; step();
    check("R11 gap cleared", gap_busy_o, 0);
    check("R11 req blocked", tx_req_o, 0);
    check("R11 words kept", count_o, 1);
    chan_rst_i = 1'b0; #1;
    check("R11 req resumes", {tx_req_o, tx_data_o}, {1'b1, 32'hD3});

    // R9/R10: disable with a word in flight
    gap_len_i = 8'd0;
    start_tx();
    en_i = 1'b0; step();
    check("R9 flushed", count_o, 0);
    check("R10 empty deferred", empty_o, 0);
    check("R9 ovf cleared", ovf_o, 0);
    push(32'hE1);
    check("R9 write ignored", count_o, 0);
    tx_done_i = 1'b1; step(); tx_done_i = 1'b0;
    check("R10 empty after done", empty_o, 1);

    // R10: disable with nothing in flight -> empty next edge
    en_i = 1'b1; step();
    push(32'hE2);
    check("R9 write accepted", count_o, 1);
    en_i = 1'b0; step();
    check("R10 immediate empty", {empty_o, tx_req_o}, {1'b1, 1'b0});

    // R9: disable stops a running gap
    en_i = 1'b1; gap_len_i = 8'd4; presc_i = 16'd8; step();
    push(32'hE3);
    send_ok();
    check("R9 gap running", gap_busy_o, 1);
    en_i = 1'b0; step();
    check("R9 gap cleared", gap_busy_o, 0);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule